// File: doc/BRIEF.md
# Half-Bridge Interlock and Fault Guard

This block is the low-side control logic of a multi-channel gate driver. It receives on/off commands for several high/low channel pairs (one pair per half-bridge) plus one auxiliary low-side channel, for example a brake chopper. It returns the gated drive commands that go on to the level shifters and output stages. A selectable cross-conduction interlock stops both switches of one half-bridge from being commanded on together. When it is enabled, an active command on either side of a pair holds the other side off.

Two fault sources gate every channel. The first is an undervoltage flag. It blocks the outputs only while it is present. The second is a shunt overcurrent comparator flag. It trips a latched fault, which raises a local error flag and pulls an active-low global error line toward the controller. The trip holds until the controller asserts a clear while the overcurrent is gone. A three-state machine tracks the condition:

- `FS_RUN`: outputs follow the commands.
- `FS_UVLO`: undervoltage is present and outputs are blocked.
- `FS_TRIP`: an overcurrent fault is latched and outputs are blocked.

The transitions are:

- RUN→TRIP and UVLO→TRIP when overcurrent is seen.
- RUN→UVLO when undervoltage is seen.
- UVLO→RUN when undervoltage drops.
- TRIP→RUN when clear is seen with no overcurrent and no undervoltage.
- TRIP→UVLO when clear is seen with no overcurrent while undervoltage is still present.

Top module: `hb_guard_ctrl`

## Requirements
- R1: While reset is held, all drive outputs are low, `loc_err` is low and `glob_err_n` is high.
- R2: With `ilock_en` high, pair i drives `top_out[i] = top_cmd[i] & ~bot_cmd[i]` and `bot_out[i] = bot_cmd[i] & ~top_cmd[i]`. If both commands are high, both outputs are low.
- R3: With `ilock_en` low, the TOP and BOT commands of each pair pass to their outputs independently. Both outputs of one pair may be high together.
- R4: A high `uv_flag` sampled at an edge forces every drive output low after that edge. It raises no error. Once the flag is sampled low, outputs follow the commands again.
- R5: A high `oc_flag` sampled at an edge sets `loc_err` high, sets `glob_err_n` low and forces every drive output low after that edge.
- R6: The overcurrent trip stays latched until `clr_fault` is sampled high in the same cycle that `oc_flag` is sampled low. A clear while `oc_flag` is high is ignored. A clear with no trip latched has no effect.
- R7: The auxiliary channel `aux_out` follows `aux_cmd` regardless of the interlock and of the pair commands. It is still blocked by undervoltage and by a latched trip.
- R8: Every output is a register updated on the same clock edge. A change of any input shows at the outputs exactly one edge later and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| top_cmd | input | NPAIR | High-side on-commands, one per pair |
| bot_cmd | input | NPAIR | Low-side on-commands, one per pair |
| aux_cmd | input | 1 | Auxiliary low-side channel command |
| ilock_en | input | 1 | Enables the per-pair interlock |
| uv_flag | input | 1 | Undervoltage present |
| oc_flag | input | 1 | Shunt overcurrent comparator output |
| clr_fault | input | 1 | Request to clear a latched trip |
| top_out | output | NPAIR | Gated high-side commands |
| bot_out | output | NPAIR | Gated low-side commands |
| aux_out | output | 1 | Gated auxiliary command |
| loc_err | output | 1 | Local latched-trip flag |
| glob_err_n | output | 1 | Global error to the controller, active low |

## Verification
The assertions check the following on every cycle:

- An interlocked pair never turns on against the other side's active command.
- Undervoltage and overcurrent both blank every output one edge later.
- A trip cannot release without a valid clear.
- A rising error always follows a sampled overcurrent.
- Unblocked commands reach their outputs in one edge.

Only the bench scenarios can show some other behaviour. These are the exact output values across all command combinations with the interlock on and off, and the release from undervoltage with no error left behind. They also cover the ignored clear while overcurrent persists, the TRIP-to-UVLO exit, and the absence of any output change before the edge.

// File: rtl/hb_guard_pkg.sv
package hb_guard_pkg;
    typedef enum logic [1:0] {
        FS_RUN  = 2'd0,
        FS_UVLO = 2'd1,
        FS_TRIP = 2'd2
    } fault_st_e;
endpackage

// File: rtl/hb_pair_gate.sv
// Cross-conduction gate for one half-bridge pair (combinational).
module hb_pair_gate (
    input  logic top_i,
    input  logic bot_i,
    input  logic ilock_i,
    output logic top_o,
    output logic bot_o
);
    always_comb begin
        top_o = top_i & ~(ilock_i & bot_i);
        bot_o = bot_i & ~(ilock_i & top_i);
    end
endmodule

// File: rtl/hb_fault_fsm.sv
// Fault state machine: undervoltage blocking and latched overcurrent trip.
module hb_fault_fsm
    import hb_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic uv_i,
    input  logic oc_i,
    input  logic clr_i,
    output logic drive_ok_o,
    output logic err_o,
    output logic err_n_o
);
    fault_st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_RUN: begin
                if (oc_i)      state_d = FS_TRIP;
                else if (uv_i) state_d = FS_UVLO;
            end
            FS_UVLO: begin
                if (oc_i)       state_d = FS_TRIP;
                else if (!uv_i) state_d = FS_RUN;
            end
            FS_TRIP: begin
                if (clr_i && !oc_i) state_d = uv_i ? FS_UVLO : FS_RUN;
            end
            default: state_d = FS_TRIP;
        endcase
    end

    // Drive permission for the output registers, taken from the next state.
    assign drive_ok_o = (state_d == FS_RUN);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_RUN;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_o   <= 1'b0;
            err_n_o <= 1'b1;
        end else begin
            err_o   <= (state_d == FS_TRIP);
            err_n_o <= (state_d != FS_TRIP);
        end
    end

    // R6: a latched trip holds unless a clear arrives without overcurrent
    p_trip_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_TRIP && !(clr_i && !oc_i)) |=> (state_q == FS_TRIP));

    // R5: the error flag only rises after a sampled overcurrent
    p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(oc_i));
endmodule

// File: rtl/hb_out_stage.sv
// Common output register bank: all channels update on one edge.
module hb_out_stage #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q_o <= '0;
        else if (en_i) q_o <= d_i;
        else           q_o <= '0;
    end
endmodule

// File: rtl/hb_guard_ctrl.sv
// Top: per-pair interlock, auxiliary channel and fault gating.
module hb_guard_ctrl #(
    parameter int NPAIR = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPAIR-1:0] top_cmd,
    input  logic [NPAIR-1:0] bot_cmd,
    input  logic             aux_cmd,
    input  logic             ilock_en,
    input  logic             uv_flag,
    input  logic             oc_flag,
    input  logic             clr_fault,
    output logic [NPAIR-1:0] top_out,
    output logic [NPAIR-1:0] bot_out,
    output logic             aux_out,
    output logic             loc_err,
    output logic             glob_err_n
);
    localparam int NCH = 2 * NPAIR + 1;

    logic [NPAIR-1:0] top_g, bot_g;
    logic             drive_ok;
    logic [NCH-1:0]   ch_d, ch_q;

    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        hb_pair_gate u_gate (
            .top_i   (top_cmd[i]),
            .bot_i   (bot_cmd[i]),
            .ilock_i (ilock_en),
            .top_o   (top_g[i]),
            .bot_o   (bot_g[i])
        );

        // R2: interlock keeps each side off against the other's command
        p_ilock_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (ilock_en && bot_cmd[i]) |=> !top_out[i]);
        p_ilock_bot_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (ilock_en && top_cmd[i]) |=> !bot_out[i]);
        // R3/R8: unblocked pass-through appears one edge later
        p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!ilock_en && !uv_flag && !oc_flag && !loc_err && top_cmd[i] && bot_cmd[i])
            |=> (top_out[i] && bot_out[i]));
    end

    hb_fault_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .uv_i       (uv_flag),
        .oc_i       (oc_flag),
        .clr_i      (clr_fault),
        .drive_ok_o (drive_ok),
        .err_o      (loc_err),
        .err_n_o    (glob_err_n)
    );

    assign ch_d = {aux_cmd, bot_g, top_g};

    hb_out_stage #(.W(NCH)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (drive_ok),
        .d_i   (ch_d),
        .q_o   (ch_q)
    );

    assign top_out = ch_q[NPAIR-1:0];
    assign bot_out = ch_q[2*NPAIR-1:NPAIR];
    assign aux_out = ch_q[NCH-1];

    // R4: undervoltage blanks every channel after the edge
    p_uv_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> (top_out == '0 && bot_out == '0 && !aux_out));
    // R5: overcurrent trips, flags and blanks
    p_oc_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oc_flag |=> (loc_err && !glob_err_n && top_out == '0 && bot_out == '0 && !aux_out));
    // R7: auxiliary channel follows its command when unblocked
    p_aux_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_cmd && !uv_flag && !oc_flag && !loc_err) |=> aux_out);
endmodule

// File: tb/hb_guard_ctrl_tb.sv
module hb_guard_ctrl_tb;
    localparam int NP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] top_cmd = '0, bot_cmd = '0;
    logic aux_cmd = 1'b0, ilock_en = 1'b0, uv_flag = 1'b0, oc_flag = 1'b0, clr_fault = 1'b0;
    logic [NP-1:0] top_out, bot_out;
    logic aux_out, loc_err, glob_err_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural model state
    bit m_trip = 1'b0;
    logic [NP-1:0] e_top = '0, e_bot = '0;
    logic e_aux = 1'b0, e_loc = 1'b0, e_gn = 1'b1;

    always #5 clk = ~clk;

    hb_guard_ctrl #(.NPAIR(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .top_cmd(top_cmd), .bot_cmd(bot_cmd),
        .aux_cmd(aux_cmd), .ilock_en(ilock_en), .uv_flag(uv_flag),
        .oc_flag(oc_flag), .clr_fault(clr_fault), .top_out(top_out),
        .bot_out(bot_out), .aux_out(aux_out), .loc_err(loc_err),
        .glob_err_n(glob_err_n)
    );

    task automatic compare(input string tag);
        logic [2*NP+2:0] act, exp;
        act = {top_out, bot_out, aux_out, loc_err, glob_err_n};
        exp = {e_top, e_bot, e_aux, e_loc, e_gn};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {top,bot,aux,loc,gerr_n} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Update the model from the inputs sampled at this edge.
    task automatic model_edge();
        bit run;
        if (!m_trip && oc_flag)                   m_trip = 1'b1;
        else if (m_trip && clr_fault && !oc_flag) m_trip = 1'b0;
        run = !m_trip && !uv_flag;
        for (int i = 0; i < NP; i++) begin
            e_top[i] = run && top_cmd[i] && !(ilock_en && bot_cmd[i]);
            e_bot[i] = run && bot_cmd[i] && !(ilock_en && top_cmd[i]);
        end
        e_aux = run && aux_cmd;
        e_loc = m_trip;
        e_gn  = !m_trip;
    endtask

    // Apply inputs after a falling edge, check no early change (R8),
    // then check the result after the next rising edge.
    task automatic step(input string tag, input logic [NP-1:0] t, input logic [NP-1:0] b,
                        input logic a, input logic il, input logic uv, input logic oc,
                        input logic clr);
        top_cmd = t; bot_cmd = b; aux_cmd = a; ilock_en = il;
        uv_flag = uv; oc_flag = oc; clr_fault = clr;
        #1;
        compare("R8 no change before edge");
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        model_edge();
        compare("R1 after release");

        // R2: all command combinations with interlock enabled
        for (int p = 0; p < 64; p++)
            step("R2 interlock on", p[2:0], p[5:3], p[0], 1'b1, 1'b0, 1'b0, 1'b0);
        // R3: interlock disabled, both sides together
        for (int p = 0; p < 64; p++)
            step("R3 interlock off", p[5:3], p[2:0], p[1], 1'b0, 1'b0, 1'b0, 1'b0);
        // R7: aux independent of pairs and interlock
        step("R7 aux with all pairs on", 3'b111, 3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        step("R7 aux off", 3'b111, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        step("R7 aux alone", 3'b000, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R4: undervoltage blocks, not latched
        step("R4 uv blocks", 3'b101, 3'b010, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        step("R4 uv held", 3'b011, 3'b100, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        step("R4 uv release", 3'b011, 3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R6: clear with no trip has no effect
        step("R6 idle clear", 3'b001, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        // R5: overcurrent trip
        step("R5 oc trip", 3'b111, 3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        step("R5 trip held after oc drops", 3'b111, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R6: clear ignored while oc persists, then accepted
        step("R6 clear with oc ignored", 3'b111, 3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        step("R6 still latched", 3'b111, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R6 clear accepted", 3'b110, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        step("R6 running again", 3'b110, 3'b001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        // R6: clear during undervoltage goes to UV blocking
        step("R5 trip during uv", 3'b111, 3'b000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        step("R6 clear into uv", 3'b111, 3'b000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        step("R4 uv drops after clear", 3'b111, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R1: reset mid-run
        rst_n = 1'b0;
        #1;
        m_trip = 1'b0; e_top = '0; e_bot = '0; e_aux = 1'b0; e_loc = 1'b0; e_gn = 1'b1;
        compare("R1 async reset");
        @(negedge clk);
        rst_n = 1'b1;
        step("R8 after reset", 3'b010, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule